// File: doc/BRIEF.md
# Early Receive Interrupt Threshold Unit

This block raises an early interrupt while a received packet is still being copied to host memory, so that software can start on the packet before it is complete. Each cycle it compares the number of bytes already moved to the host with a threshold. It then emits a single-cycle pulse, at most once per packet, when that threshold is met.

The threshold is chosen per packet from one of two sources. The first is a fraction of the packet length, set in sixteenths by a 4-bit field. The second is an absolute byte count held in a 12-bit value. A mode input forces every packet onto the absolute count. With the mode input clear, a flag from an upstream parser picks the source: a recognised protocol uses the fraction and an unrecognised one uses the absolute count. The fraction is tested as `bytes*16 >= length*k`, so no divider is needed. Protocol parsing is not part of this block.

Top module: `early_rx_irq`

## Requirements
- R1: After synchronous reset `early_irq` is 0, and no pulse occurs until `pkt_start` has been seen.
- R2: With `all_abs`=0, `proto_known`=1 and `frac_sel`=k in 1..15, the block pulses once `xfer_bytes*16 >= pkt_len*k`. The pulse is seen in the cycle after the clock edge that sampled the crossing, and an exact equality counts as reached.
- R3: With `all_abs`=0, `proto_known`=1 and `frac_sel`=0, no early pulse is raised for the packet.
- R4: With `all_abs`=1, every packet uses `abs_count` as its threshold, whatever the values of `frac_sel` and `proto_known`.
- R5: With `all_abs`=0 and `proto_known`=0, the packet uses `abs_count` as its threshold.
- R6: `abs_count` is 12 bits wide. A nonzero value fires when `xfer_bytes >= abs_count`, and the value 0 disables the absolute threshold.
- R7: A packet yields at most one pulse, and each pulse lasts exactly one cycle, even if the threshold stays met.
- R8: `pkt_start` re-arms the unit for a new packet. No comparison is made in the cycle in which `pkt_start` is high.
- R9: In a cycle with `pkt_done`=1, no pulse is raised, even if the threshold is also met in that cycle. The packet is then disarmed until the next `pkt_start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pkt_start | input | 1 | One-cycle marker of a new packet |
| pkt_done | input | 1 | Packet fully transferred in this cycle |
| pkt_len | input | 16 | Length of the current packet in bytes |
| xfer_bytes | input | 16 | Bytes of the current packet moved to host memory |
| proto_known | input | 1 | Packet protocol recognised by the parser |
| frac_sel | input | 4 | Fraction in sixteenths; 0 disables the fraction |
| abs_count | input | 12 | Absolute byte threshold; 0 disables it |
| all_abs | input | 1 | 1: every packet uses `abs_count` |
| early_irq | output | 1 | Single-cycle early interrupt pulse |

## Verification
Two events can fall in the same cycle: a packet completing and its threshold being crossed. The bench provokes this by stepping the byte count so that it jumps past the fractional threshold exactly when `pkt_done` is raised. A correct design must then stay silent, because completion has priority.

A similar collision is tested at the start of a packet. The bench holds a stale, already-passing byte count during the `pkt_start` cycle and checks that the pulse appears only one cycle later. In both cases a behavioural reference model gives the expected output on every clock, and per-packet pulse counts are compared as well.

// File: rtl/early_rx_pkg.sv
// Package: shared types for the early receive interrupt unit.
// Assumes: nothing beyond the SystemVerilog 2017 language.
package early_rx_pkg;
    // Per-packet arming state.
    typedef enum logic [1:0] {
        ERX_IDLE  = 2'd0,
        ERX_WATCH = 2'd1,
        ERX_SPENT = 2'd2
    } erx_state_e;
endpackage

// File: rtl/early_rx_frac_cmp.sv
// Module: fractional threshold comparator.
// Tests xfer*2^FRAC_W >= len*k without a divider. The product len*k is
// built as a shift-add over the bits of k. A zero k yields no hit.
// Assumes: k is in units of 1/2^FRAC_W of the packet length.
module early_rx_frac_cmp #(
    parameter int LEN_W  = 16,
    parameter int FRAC_W = 4
) (
    input  logic [LEN_W-1:0]  len,
    input  logic [LEN_W-1:0]  xfer,
    input  logic [FRAC_W-1:0] frac,
    output logic              hit
);
    localparam int PROD_W = LEN_W + FRAC_W;

    logic [PROD_W-1:0] partial [FRAC_W];
    logic [PROD_W-1:0] need;
    logic [PROD_W-1:0] scaled;

    // One partial product per bit of the fraction.
    for (genvar i = 0; i < FRAC_W; i++) begin : g_pp
        assign partial[i] = frac[i] ? (PROD_W'(len) << i) : '0;
    end

    // Sum the partial products into len*k.
    always_comb begin
        need = '0;
        for (int i = 0; i < FRAC_W; i++) begin
            need = need + partial[i];
        end
    end

    assign scaled = {xfer, {FRAC_W{1'b0}}};

    // Hit only when the fraction is enabled and reached.
    assign hit = (frac != '0) && (scaled >= need);
endmodule

// File: rtl/early_rx_abs_cmp.sv
// Module: absolute byte-count threshold comparator.
// A zero count disables it. Otherwise it hits when xfer >= count.
// Assumes: both operands are unsigned byte counts.
module early_rx_abs_cmp #(
    parameter int LEN_W = 16,
    parameter int CNT_W = 12
) (
    input  logic [LEN_W-1:0] xfer,
    input  logic [CNT_W-1:0] count,
    output logic             hit
);
    localparam int CMP_W = (LEN_W > CNT_W) ? LEN_W : CNT_W;

    logic [CMP_W-1:0] xfer_w;
    logic [CMP_W-1:0] count_w;

    assign xfer_w  = CMP_W'(xfer);
    assign count_w = CMP_W'(count);

    // Hit when enabled and reached.
    assign hit = (count != '0) && (xfer_w >= count_w);
endmodule

// File: rtl/early_rx_arm_ctrl.sv
// Module: per-packet arming control and pulse register.
// Start re-arms. Done disarms and blocks a pulse in the same cycle.
// The first hit while armed produces a single registered pulse.
// Assumes: start and done are single-cycle markers from the DMA side.
module early_rx_arm_ctrl
    import early_rx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pkt_start,
    input  logic pkt_done,
    input  logic hit,
    output logic early_irq
);
    erx_state_e state_q, state_d;
    logic       fire;
    logic       irq_q;

    // Next state and pulse request; start has top priority, then done.
    always_comb begin
        state_d = state_q;
        fire    = 1'b0;
        if (pkt_start) begin
            state_d = ERX_WATCH;
        end else begin
            case (state_q)
                ERX_WATCH: begin
                    if (pkt_done) begin
                        state_d = ERX_IDLE;
                    end else if (hit) begin
                        state_d = ERX_SPENT;
                        fire    = 1'b1;
                    end
                end
                ERX_SPENT: begin
                    if (pkt_done) state_d = ERX_IDLE;
                end
                default: state_d = state_q;
            endcase
        end
    end

    // State and output registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ERX_IDLE;
            irq_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            irq_q   <= fire;
        end
    end

    assign early_irq = irq_q;
endmodule

// File: rtl/early_rx_irq.sv
// Module: early receive interrupt threshold unit (top).
// Selects, per packet, either the fractional or the absolute threshold.
// The choice follows the mode bit and the protocol flag. It then drives
// a single-cycle early interrupt at most once per packet.
// Assumes: inputs are synchronous to clk; proto_known is valid during the
// packet.
module early_rx_irq #(
    parameter int LEN_W  = 16,
    parameter int FRAC_W = 4,
    parameter int CNT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_start,
    input  logic              pkt_done,
    input  logic [LEN_W-1:0]  pkt_len,
    input  logic [LEN_W-1:0]  xfer_bytes,
    input  logic              proto_known,
    input  logic [FRAC_W-1:0] frac_sel,
    input  logic [CNT_W-1:0]  abs_count,
    input  logic              all_abs,
    output logic              early_irq
);
    logic frac_hit;
    logic abs_hit;
    logic use_abs;
    logic sel_hit;

    early_rx_frac_cmp #(.LEN_W(LEN_W), .FRAC_W(FRAC_W)) u_frac (
        .len  (pkt_len),
        .xfer (xfer_bytes),
        .frac (frac_sel),
        .hit  (frac_hit)
    );

    early_rx_abs_cmp #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_abs (
        .xfer  (xfer_bytes),
        .count (abs_count),
        .hit   (abs_hit)
    );

    // Source select: forced absolute, or absolute for unknown protocols.
    assign use_abs = all_abs | ~proto_known;
    assign sel_hit = use_abs ? abs_hit : frac_hit;

    early_rx_arm_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .pkt_start (pkt_start),
        .pkt_done  (pkt_done),
        .hit       (sel_hit),
        .early_irq (early_irq)
    );
endmodule

// File: rtl/early_rx_irq_chk.sv
// Module: assertion checker for early_rx_irq, attached by bind.
// Keeps its own start/fired flags and recomputes the threshold test
// with a plain multiplication.
module early_rx_irq_chk #(
    parameter int LEN_W  = 16,
    parameter int FRAC_W = 4,
    parameter int CNT_W  = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pkt_start,
    input logic              pkt_done,
    input logic [LEN_W-1:0]  pkt_len,
    input logic [LEN_W-1:0]  xfer_bytes,
    input logic              proto_known,
    input logic [FRAC_W-1:0] frac_sel,
    input logic [CNT_W-1:0]  abs_count,
    input logic              all_abs,
    input logic              early_irq
);
    localparam int PW = LEN_W + FRAC_W + 1;

    logic chk_use_abs;
    logic chk_frac_ok;
    logic chk_abs_ok;
    logic chk_hit;
    logic started_q;
    logic fired_q;

    assign chk_use_abs = all_abs || !proto_known;
    assign chk_frac_ok = (frac_sel != '0) &&
        ((PW'(xfer_bytes) * PW'(2 ** FRAC_W)) >= (PW'(pkt_len) * PW'(frac_sel)));
    assign chk_abs_ok  = (abs_count != '0) && (PW'(xfer_bytes) >= PW'(abs_count));
    assign chk_hit     = chk_use_abs ? chk_abs_ok : chk_frac_ok;

    // Track whether a packet began since reset and whether it has pulsed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            started_q <= 1'b0;
            fired_q   <= 1'b0;
        end else begin
            started_q <= started_q | pkt_start;
            fired_q   <= pkt_start ? 1'b0 : (fired_q | early_irq);
        end
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        early_irq |-> started_q);

    // R2
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        early_irq |-> $past(chk_hit));

    // R3
    frac_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!all_abs && proto_known && frac_sel == '0) |=> !early_irq);

    // R6
    abs_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_use_abs && abs_count == '0) |=> !early_irq);

    // R7
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        early_irq |=> !early_irq);

    // R7
    one_per_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        early_irq |-> !fired_q);

    // R8
    start_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_start |=> !early_irq);

    // R9
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |=> !early_irq);
endmodule

bind early_rx_irq early_rx_irq_chk #(
    .LEN_W(LEN_W), .FRAC_W(FRAC_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .pkt_done(pkt_done),
    .pkt_len(pkt_len), .xfer_bytes(xfer_bytes), .proto_known(proto_known),
    .frac_sel(frac_sel), .abs_count(abs_count), .all_abs(all_abs),
    .early_irq(early_irq)
);

// File: tb/early_rx_irq_bench.sv
module early_rx_irq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pkt_start = 1'b0;
    logic        pkt_done = 1'b0;
    logic [15:0] pkt_len = '0;
    logic [15:0] xfer_bytes = '0;
    logic        proto_known = 1'b0;
    logic [3:0]  frac_sel = '0;
    logic [11:0] abs_count = '0;
    logic        all_abs = 1'b0;
    logic        early_irq;

    int    checks = 0;
    int    errors = 0;
    int    pulses = 0;
    int    m_state = 0;
    bit    exp_irq = 1'b0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    early_rx_irq u_early_rx_irq (
        .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .pkt_done(pkt_done),
        .pkt_len(pkt_len), .xfer_bytes(xfer_bytes), .proto_known(proto_known),
        .frac_sel(frac_sel), .abs_count(abs_count), .all_abs(all_abs),
        .early_irq(early_irq)
    );

    // Reference threshold test: the fraction uses a rounded-up byte count.
    function automatic bit ref_hit();
        int thr;
        if (all_abs || !proto_known) begin
            if (abs_count == 0) return 1'b0;
            thr = int'(abs_count);
        end else begin
            if (frac_sel == 0) return 1'b0;
            thr = (int'(pkt_len) * int'(frac_sel) + 15) / 16;
        end
        return int'(xfer_bytes) >= thr;
    endfunction

    // Reference model: 0 no packet, 1 watching, 2 already pulsed.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0;
            exp_irq = 1'b0;
        end else begin
            exp_irq = 1'b0;
            if (pkt_start) m_state = 1;
            else if (m_state == 1) begin
                if (pkt_done) m_state = 0;
                else if (ref_hit()) begin
                    exp_irq = 1'b1;
                    m_state = 2;
                end
            end else if (m_state == 2 && pkt_done) m_state = 0;
        end
    end

    // Compare with the model on every clock, away from the edge.
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            checks++;
            if (early_irq !== exp_irq) begin
                errors++;
                $display("FAIL %s: early_irq=%0b expected %0b at %0t",
                         cur_req, early_irq, exp_irq, $time);
            end
            if (early_irq === 1'b1) pulses++;
        end
    end

    task automatic check_pulses(input string tag, input int expv);
        checks++;
        if (pulses != expv) begin
            errors++;
            $display("FAIL %s: pulses=%0d expected %0d", tag, pulses, expv);
        end
    endtask

    // Run one packet: start, then advance the byte count by step each cycle.
    task automatic run_pkt(input string tag, input int len, input int step,
                           input bit mode, input bit proto, input int k,
                           input int ab, input int exp_pulses);
        int x = 0;
        @(negedge clk);
        cur_req = tag;
        pulses = 0;
        all_abs = mode; proto_known = proto;
        frac_sel = 4'(k); abs_count = 12'(ab);
        pkt_len = 16'(len); xfer_bytes = '0; pkt_start = 1'b1;
        @(negedge clk);
        pkt_start = 1'b0;
        while (x < len) begin
            x = (x + step > len) ? len : x + step;
            xfer_bytes = 16'(x);
            pkt_done = (x == len);
            @(negedge clk);
        end
        pkt_done = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check_pulses(tag, exp_pulses);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset value, and no pulse with passing inputs before any start
        checks++;
        if (early_irq !== 1'b0) begin
            errors++;
            $display("FAIL R1: early_irq=%0b expected 0 in reset", early_irq);
        end
        rst_n = 1'b1;
        cur_req = "R1";
        proto_known = 1'b1; frac_sel = 4'd1; pkt_len = 16'd16; xfer_bytes = 16'd16;
        pulses = 0;
        repeat (5) @(negedge clk);
        check_pulses("R1", 0);

        // R2: fraction in several patterns, including exact equality
        run_pkt("R2", 100, 7, 1'b0, 1'b1, 5, 0, 1);
        run_pkt("R2", 64, 4, 1'b0, 1'b1, 4, 0, 1);
        run_pkt("R2", 1500, 33, 1'b0, 1'b1, 15, 4095, 1);
        run_pkt("R2", 60000, 1000, 1'b0, 1'b1, 9, 0, 1);
        // R3: fraction field zero disables
        run_pkt("R3", 200, 10, 1'b0, 1'b1, 0, 20, 0);
        // R4: mode set forces the absolute count
        run_pkt("R4", 300, 10, 1'b1, 1'b1, 1, 150, 1);
        run_pkt("R4", 300, 10, 1'b1, 1'b1, 15, 0, 0);
        // R5: unrecognised protocol uses the absolute count
        run_pkt("R5", 400, 9, 1'b0, 1'b0, 1, 50, 1);
        run_pkt("R5", 400, 9, 1'b0, 1'b0, 8, 0, 0);
        // R6: full 12-bit count, and above packet end
        run_pkt("R6", 5000, 100, 1'b1, 1'b0, 0, 4095, 1);
        run_pkt("R6", 100, 5, 1'b1, 1'b0, 0, 101, 0);
        // R7: small step keeps the threshold met for many cycles
        run_pkt("R7", 256, 1, 1'b0, 1'b1, 2, 0, 1);
        // R9: crossing and completion in the same cycle -> no pulse
        run_pkt("R9", 32, 16, 1'b0, 1'b1, 15, 0, 0);
        run_pkt("R9", 48, 48, 1'b1, 1'b1, 0, 1, 0);

        // R8: stale passing count during the start cycle
        @(negedge clk);
        cur_req = "R8";
        pulses = 0;
        all_abs = 1'b0; proto_known = 1'b1; frac_sel = 4'd8;
        pkt_len = 16'd40; xfer_bytes = 16'd40; pkt_start = 1'b1;
        @(negedge clk);
        pkt_start = 1'b0;
        #2;
        checks++;
        if (early_irq !== 1'b0) begin
            errors++;
            $display("FAIL R8: early_irq=%0b expected 0 after start", early_irq);
        end
        @(negedge clk);
        @(negedge clk);
        // R8: re-arm with a second start for the same spent packet
        pkt_start = 1'b1;
        @(negedge clk);
        pkt_start = 1'b0;
        @(negedge clk);
        pkt_done = 1'b1;
        @(negedge clk);
        pkt_done = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check_pulses("R8", 2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule